// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block sits between a bank of general-purpose input pins and a processor interrupt controller. Every pin is first brought into the local clock domain by a two-stage synchronizer. It can then pass through a debounce filter, which accepts a new level only after that level has held for a programmable number of prescaled clock ticks. After that, each pin is judged as a level or as an edge of the chosen polarity.

Detected events collect in a raw status vector. The raw status is gated by a per-pin mask to form the masked status. The single interrupt output is the OR of the masked status. Level events track the filtered input. Edge events stay latched until software clears them by writing ones to an end-of-interrupt register.

Software reaches all settings through a zero-wait APB-style slave port. A typical use is to enable one pin, leave it unmasked and set it to active-high level. The block then acts as a plain wire for one cascaded interrupt line.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register reads 0, both status registers read 0 and `irq_o` is 0.
- R2: Registers decode at these byte offsets: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, debounce enable 0x48 and debounce length 0x50 (low 8 bits) are read/write. Masked status 0x40 and raw status 0x44 are read-only, and writes to them have no effect. End-of-interrupt 0x4C is write-only and reads 0. A register changes only when it is written.
- R3: A raw status bit can be 1 only while that pin's enable bit is 1. Clearing the enable bit clears the pin's status.
- R4: A mask bit of 1 removes the pin from the masked status and from `irq_o`, while its raw status still shows the event. A mask bit of 0 passes the event through.
- R5: A type bit of 0 selects level detection. The raw bit is then 1 while the filtered input is high (polarity 1) or low (polarity 0).
- R6: A type bit of 1 selects edge detection. A rising edge (polarity 1) or a falling edge (polarity 0) sets the raw bit. The bit stays set after the input returns, and edges of the opposite direction do not set it.
- R7: Writing 1 to a bit of the end-of-interrupt register clears a latched edge event. Bits written as 0 leave events untouched, and level-type bits are not affected.
- R8: With debounce enabled for a pin, a pulse shorter than (length+1) ticks is ignored, and a level held long enough is accepted. With debounce disabled, a two-cycle pulse is detected.
- R9: `irq_o` is 1 exactly when some masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| gpio_i | input | 32 | Asynchronous input pins |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the debounce filter rejecting a glitch. The pulse must be shorter than the debounce window yet wide enough to survive the synchronizer, and it must come while the pin is already configured for edge detection. The stimulus arms a rising-edge pin with debounce on, clears any stale event, and drives a two-cycle pulse. It then repeats a held level and the same pulse with debounce off. This shows that the window is what makes the difference.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFS_INTEN = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_TYPE  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RSTAT = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_DBEN  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_EOI   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_DBLEN = 8'h50;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [NPINS-1:0]  raw_i,
    input  logic [NPINS-1:0]  mstat_i,
    output logic [NPINS-1:0]  en_q_o,
    output logic [NPINS-1:0]  en_d_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  typ_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  dben_o,
    output logic [LEN_W-1:0]  dblen_o,
    output logic [NPINS-1:0]  eoi_o
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] mask;
        logic [NPINS-1:0] typ;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] dben;
        logic [LEN_W-1:0] dblen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wr_en;

    assign wr_en = psel && penable && pwrite;

    always_comb begin
        cfg_d = cfg_q;
        eoi_o = '0;
        if (wr_en) begin
            case (paddr)
                OFS_INTEN: cfg_d.en    = pwdata[NPINS-1:0];
                OFS_MASK:  cfg_d.mask  = pwdata[NPINS-1:0];
                OFS_TYPE:  cfg_d.typ   = pwdata[NPINS-1:0];
                OFS_POL:   cfg_d.pol   = pwdata[NPINS-1:0];
                OFS_DBEN:  cfg_d.dben  = pwdata[NPINS-1:0];
                OFS_DBLEN: cfg_d.dblen = pwdata[LEN_W-1:0];
                OFS_EOI:   eoi_o       = pwdata[NPINS-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        case (paddr)
            OFS_INTEN: prdata[NPINS-1:0] = cfg_q.en;
            OFS_MASK:  prdata[NPINS-1:0] = cfg_q.mask;
            OFS_TYPE:  prdata[NPINS-1:0] = cfg_q.typ;
            OFS_POL:   prdata[NPINS-1:0] = cfg_q.pol;
            OFS_DBEN:  prdata[NPINS-1:0] = cfg_q.dben;
            OFS_DBLEN: prdata[LEN_W-1:0] = cfg_q.dblen;
            OFS_MSTAT: prdata[NPINS-1:0] = mstat_i;
            OFS_RSTAT: prdata[NPINS-1:0] = raw_i;
            default:   prdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_q_o  = cfg_q.en;
    assign en_d_o  = cfg_d.en;
    assign mask_o  = cfg_q.mask;
    assign typ_o   = cfg_q.typ;
    assign pol_o   = cfg_q.pol;
    assign dben_o  = cfg_q.dben;
    assign dblen_o = cfg_q.dblen;

    // A register only moves when it is written
    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && paddr == OFS_INTEN) |=> $stable(cfg_q.en));
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && paddr == OFS_MASK) |=> $stable(cfg_q.mask));
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
    parameter int NPINS    = 32,
    parameter int LEN_W    = 8,
    parameter int TICK_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] dben_i,
    input  logic [LEN_W-1:0] dblen_i,
    output logic [NPINS-1:0] filt_o
);
    localparam int TICK_W = $clog2(TICK_DIV + 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [NPINS-1:0]            s1;
        logic [NPINS-1:0]            s2;
        logic [NPINS-1:0]            filt;
        logic [NPINS-1:0][LEN_W-1:0] cnt;
        logic [TICK_W-1:0]           tick_cnt;
    } flt_t;

    flt_t st_d, st_q;
    logic tick;

    assign tick = (st_q.tick_cnt == TICK_LAST);

    always_comb begin
        st_d          = st_q;
        st_d.s1       = pin_i;
        st_d.s2       = st_q.s1;
        st_d.tick_cnt = tick ? '0 : st_q.tick_cnt + 1'b1;
        for (int i = 0; i < NPINS; i++) begin
            if (!dben_i[i]) begin
                st_d.filt[i] = st_q.s2[i];
                st_d.cnt[i]  = '0;
            end else if (st_q.s2[i] == st_q.filt[i]) begin
                st_d.cnt[i]  = '0;
            end else if (tick) begin
                if (st_q.cnt[i] == dblen_i) begin
                    st_d.filt[i] = st_q.s2[i];
                    st_d.cnt[i]  = '0;
                end else begin
                    st_d.cnt[i]  = st_q.cnt[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = st_q.filt;

    // With debounce on, the filtered value only ever takes the synchronized value
    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        assert_db_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dben_i[g]) && !$stable(st_q.filt[g])) |-> (st_q.filt[g] == $past(st_q.s2[g])));
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] filt_i,
    input  logic [NPINS-1:0] en_q_i,
    input  logic [NPINS-1:0] en_d_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [NPINS-1:0] typ_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] eoi_i,
    output logic [NPINS-1:0] raw_o,
    output logic [NPINS-1:0] mstat_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] raw;
    } det_t;

    det_t st_d, st_q;
    logic [NPINS-1:0] hit, lvl;

    always_comb begin
        st_d      = st_q;
        st_d.prev = filt_i;
        for (int i = 0; i < NPINS; i++) begin
            hit[i] = pol_i[i] ? (filt_i[i] & ~st_q.prev[i]) : (~filt_i[i] & st_q.prev[i]);
            lvl[i] = pol_i[i] ? filt_i[i] : ~filt_i[i];
            if (!en_d_i[i])
                st_d.raw[i] = 1'b0;
            else if (typ_i[i])
                st_d.raw[i] = (st_q.raw[i] & ~eoi_i[i]) | hit[i];
            else
                st_d.raw[i] = lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o   = st_q.raw;
    assign mstat_o = st_q.raw & ~mask_i;
    assign irq_o   = |mstat_o;

    assert_raw_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.raw & ~en_q_i) == '0);
    assert_full_mask_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |-> !irq_o);
    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.raw[g] && typ_i[g] && en_d_i[g] && !eoi_i[g]) |=> st_q.raw[g]);
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int LEN_W    = 8,
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [NPINS-1:0]  gpio_i,
    output logic              irq_o
);
    logic [NPINS-1:0] en_q, en_d, mask, typ, pol, dben, eoi, filt, raw, mstat;
    logic [LEN_W-1:0] dblen;

    gpio_irq_regs #(.NPINS(NPINS), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .raw_i(raw), .mstat_i(mstat),
        .en_q_o(en_q), .en_d_o(en_d), .mask_o(mask), .typ_o(typ), .pol_o(pol),
        .dben_o(dben), .dblen_o(dblen), .eoi_o(eoi)
    );

    gpio_irq_filter #(.NPINS(NPINS), .LEN_W(LEN_W), .TICK_DIV(TICK_DIV)) u_filter (
        .clk(clk), .rst_n(rst_n), .pin_i(gpio_i), .dben_i(dben), .dblen_i(dblen),
        .filt_o(filt)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .filt_i(filt), .en_q_i(en_q), .en_d_i(en_d),
        .mask_i(mask), .typ_i(typ), .pol_i(pol), .eoi_i(eoi),
        .raw_o(raw), .mstat_o(mstat), .irq_o(irq_o)
    );

    assert_eoi_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (paddr == OFS_EOI) |-> (prdata == '0));
endmodule

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] gpio = '0;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_i(gpio), .irq_o(irq)
    );

    typedef struct packed {
        logic [31:0] en, mask, typ, pol, in0, in1, raw, msk;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_000F, 32'h0, 32'h0, 32'h0000_000F, 32'h0, 32'h0000_0005, 32'h0000_0005, 32'h0000_0005}, // R5 high level
        '{32'h0000_00F0, 32'h0, 32'h0, 32'h0, 32'h0000_00F0, 32'h0000_0030, 32'h0000_00C0, 32'h0000_00C0}, // R5 low level
        '{32'h0000_FF00, 32'h0000_0300, 32'h0000_FF00, 32'h0000_FF00, 32'h0, 32'h0000_0F00, 32'h0000_0F00, 32'h0000_0C00}, // R6 rise, R4
        '{32'h00FF_0000, 32'h0, 32'h00FF_0000, 32'h0, 32'h00FF_0000, 32'h000F_0000, 32'h00F0_0000, 32'h00F0_0000}, // R6 fall
        '{32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0},                                // R3 disabled
        '{32'h0000_0001, 32'h0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0, 32'h0, 32'h0},              // R6 wrong direction
        '{32'h0000_000F, 32'hFFFF_FFFF, 32'h0, 32'h0000_000F, 32'h0, 32'h0000_000F, 32'h0000_000F, 32'h0}       // R4 full mask
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        foreach (VEC[0].en[k]) begin end
        apb_rd(8'h30, rd); chk("R1 enable", rd, 0);
        apb_rd(8'h34, rd); chk("R1 mask", rd, 0);
        apb_rd(8'h38, rd); chk("R1 type", rd, 0);
        apb_rd(8'h3C, rd); chk("R1 polarity", rd, 0);
        apb_rd(8'h40, rd); chk("R1 masked status", rd, 0);
        apb_rd(8'h44, rd); chk("R1 raw status", rd, 0);
        apb_rd(8'h50, rd); chk("R1 debounce length", rd, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 readback and read-only behaviour
        apb_wr(8'h34, 32'hA5A5_0F0F); apb_rd(8'h34, rd); chk("R2 mask rw", rd, 32'hA5A5_0F0F);
        apb_wr(8'h48, 32'h1234_5678); apb_rd(8'h48, rd); chk("R2 debounce enable rw", rd, 32'h1234_5678);
        apb_wr(8'h50, 32'hFFFF_FF37); apb_rd(8'h50, rd); chk("R2 debounce length rw", rd, 32'h37);
        apb_wr(8'h44, 32'hFFFF_FFFF); apb_rd(8'h44, rd); chk("R2 raw read-only", rd, 0);
        apb_wr(8'h40, 32'hFFFF_FFFF); apb_rd(8'h40, rd); chk("R2 masked read-only", rd, 0);
        apb_rd(8'h4C, rd); chk("R2 eoi reads zero", rd, 0);
        apb_wr(8'h48, 0); apb_wr(8'h50, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            apb_wr(8'h30, VEC[v].en);
            apb_wr(8'h34, VEC[v].mask);
            apb_wr(8'h38, VEC[v].typ);
            apb_wr(8'h3C, VEC[v].pol);
            gpio = VEC[v].in0;
            idle(8);
            apb_wr(8'h4C, 32'hFFFF_FFFF);
            gpio = VEC[v].in1;
            idle(8);
            apb_rd(8'h44, rd); chk($sformatf("R5/R6/R3 raw vec %0d", v), rd, VEC[v].raw);
            apb_rd(8'h40, rd); chk($sformatf("R4 masked vec %0d", v), rd, VEC[v].msk);
            chk($sformatf("R9 irq vec %0d", v), {31'b0, irq}, {31'b0, |VEC[v].msk});
        end

        // R7 end-of-interrupt: pin 8 rising edge, pin 0 high level
        apb_wr(8'h34, 0);
        apb_wr(8'h30, 32'h0000_0101);
        apb_wr(8'h38, 32'h0000_0100);
        apb_wr(8'h3C, 32'h0000_0101);
        gpio = 0; idle(8);
        apb_wr(8'h4C, 32'hFFFF_FFFF);
        gpio = 32'h0000_0101; idle(8);
        gpio = 32'h0000_0001; idle(8);
        apb_rd(8'h44, rd); chk("R6 edge stays after input drops", rd, 32'h0000_0101);
        apb_wr(8'h4C, 32'hFFFF_FEFF); idle(2);
        apb_rd(8'h44, rd); chk("R7 zero bits leave edge", rd, 32'h0000_0101);
        apb_wr(8'h4C, 32'h0000_0101); idle(2);
        apb_rd(8'h44, rd); chk("R7 clear edge, level stays", rd, 32'h0000_0001);
        chk("R9 irq with level only", {31'b0, irq}, 1);
        // R3 disable clears status
        apb_wr(8'h30, 0); idle(1);
        apb_rd(8'h44, rd); chk("R3 disable clears", rd, 0);
        chk("R9 irq low", {31'b0, irq}, 0);

        // R8 debounce on pin 0, rising edge, length 3 (4 ticks of 2 cycles)
        gpio = 0;
        apb_wr(8'h30, 1); apb_wr(8'h38, 1); apb_wr(8'h3C, 1);
        apb_wr(8'h48, 1); apb_wr(8'h50, 3);
        idle(12);
        apb_wr(8'h4C, 32'hFFFF_FFFF);
        gpio = 1; idle(2); gpio = 0; idle(20);
        apb_rd(8'h44, rd); chk("R8 short pulse ignored", rd, 0);
        gpio = 1; idle(30);
        apb_rd(8'h44, rd); chk("R8 held level accepted", rd, 1);
        gpio = 0; idle(30);
        apb_wr(8'h48, 0); idle(4);
        apb_wr(8'h4C, 32'hFFFF_FFFF);
        gpio = 1; idle(2); gpio = 0; idle(10);
        apb_rd(8'h44, rd); chk("R8 pulse seen without debounce", rd, 1);

        finish_run();
    end
endmodule